// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Controller

This block runs one DMA channel that copies data between a peripheral and memory, with the peripheral pacing the work through hardware flow control. Software supplies a first and a last memory address and a per-unit step, then sets the run control. Each time the peripheral raises its request line, the channel issues one bus access at the current address. When the bus accepts it, the channel advances the address by the step and acknowledges the peripheral.

A transfer can end in three ways. It ends normally when the running address reaches the last address. It ends early when the peripheral raises its terminate line. It ends in failure when the range is inverted or the bus reports an error. The cause is shown on a two-bit priority-encoded status code, next to busy, done and request flags. A single-cycle interrupt pulse marks the moment the channel completes. Clearing run aborts any activity, clears the latched cause and re-arms the channel.

Top module: `dmac_chan`

## Requirements
- R1: After reset every output is 0. `stat_busy` is 1 exactly while the channel sequencer is outside its idle state, and `bus_req` is only ever high while `stat_busy` is high.
- R2: While `ctl_run` is 0, peripheral requests are ignored: no bus access is issued and the channel stays idle.
- R3: `stat_req` shows the level of `periph_req` one clock later, whether or not the channel runs.
- R4: With run set, each serviced peripheral request yields one bus access with `bus_addr` equal to the current address. That address starts at `start_addr`. After each accepted access (`bus_ack` high, `bus_err` low), the address grows by `step` and `periph_ack` pulses for one cycle.
- R5: Local completion happens when the current address equals `end_addr` while the channel waits for a request. If `start_addr` equals `end_addr`, the channel completes with no bus access at all.
- R6: External completion happens when `periph_term` is high while the channel waits for a request. The channel returns to idle without issuing further accesses.
- R7: An error is latched when `end_addr < start_addr` at the moment run starts the channel, or when a bus access is answered with `bus_err`. An errored access does not advance the address. The error holds while run stays 1.
- R8: `stat_code` is 3 for error, 2 for external completion, 1 for local completion and 0 otherwise. When several causes are latched, the highest code wins. The code stays stable while done and run are both 1.
- R9: `stat_done` equals run (as registered) AND NOT busy. It is therefore 0 whenever run is off.
- R10: `irq` pulses high for exactly one cycle when a completion or error cause is first latched, and `stat_code` is nonzero in that cycle.
- R11: Clearing `ctl_run` returns the channel to idle on the next clock, clears all latched causes (status code 0) and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_run | input | 1 | Run control: 1 enables servicing of requests |
| start_addr | input | ADDR_W | First memory address of the transfer |
| end_addr | input | ADDR_W | Address at which the transfer is complete |
| step | input | STEP_W | Address increment per transfer unit |
| periph_req | input | 1 | Peripheral transfer request (level) |
| periph_term | input | 1 | Peripheral request to end the transfer early |
| periph_ack | output | 1 | One-cycle pulse per completed unit |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_addr | output | ADDR_W | Address of the current bus access |
| bus_ack | input | 1 | Bus accepts the pending access |
| bus_err | input | 1 | Error response, valid with bus_ack |
| stat_busy | output | 1 | Sequencer not idle |
| stat_done | output | 1 | Run on and sequencer idle |
| stat_req | output | 1 | Registered view of the peripheral request |
| stat_code | output | 2 | Priority-encoded completion cause |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The transfer engine is driven with a back-to-back run at step 4 and a run with two bus wait states at step 2. Comparing these shows that address stepping follows the configured step and does not depend on bus latency. A zero-length range and an inverted range separate the immediate local-done path from the start-time error path. A termination with no units, and a termination issued just as the address reaches the end, separate plain external completion from priority resolution between two causes. A bus error in the middle of a range, a run-off stretch with the request held high, and an abort mid-transfer show that the error is latched, that requests are ignored, and that the sticky causes clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_XFER  = 2'd2
  } dmac_state_e;

  // completion causes, index order is the priority order (higher wins)
  localparam int NUM_CAUSES = 3;
  localparam int CAUSE_LOCAL = 0;
  localparam int CAUSE_EXT   = 1;
  localparam int CAUSE_ERR   = 2;
  localparam int CODE_W      = $clog2(NUM_CAUSES + 1);
endpackage

// File: rtl/dmac_addr_ctr.sv
module dmac_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= addr + ADDR_W'(step);
  end

  assign at_end = (addr == end_addr);
endmodule

// File: rtl/dmac_fsm.sv
module dmac_fsm
  import dmac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  fin,
  input  logic                  bad_range,
  input  logic                  req,
  input  logic                  term,
  input  logic                  at_end,
  input  logic                  bus_ack,
  input  logic                  bus_err,
  output dmac_state_e           state,
  output logic                  load,
  output logic                  adv,
  output logic [NUM_CAUSES-1:0] set_cause
);
  dmac_state_e state_n;

  always_comb begin
    state_n   = state;
    load      = 1'b0;
    adv       = 1'b0;
    set_cause = '0;
    case (state)
      ST_IDLE: begin
        if (run && !fin) begin
          if (bad_range) begin
            set_cause[CAUSE_ERR] = 1'b1;
          end else begin
            load    = 1'b1;
            state_n = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (!run) begin
          state_n = ST_IDLE;
        end else if (at_end || term) begin
          set_cause[CAUSE_LOCAL] = at_end;
          set_cause[CAUSE_EXT]   = term;
          state_n                = ST_IDLE;
        end else if (req) begin
          state_n = ST_XFER;
        end
      end
      ST_XFER: begin
        if (!run) begin
          state_n = ST_IDLE;
        end else if (bus_ack) begin
          if (bus_err) begin
            set_cause[CAUSE_ERR] = 1'b1;
            state_n              = ST_IDLE;
          end else begin
            adv     = 1'b1;
            state_n = ST_ARMED;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_n;
  end
endmodule

// File: rtl/dmac_status.sv
module dmac_status
  import dmac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  req,
  input  logic                  busy,
  input  logic [NUM_CAUSES-1:0] set_cause,
  output logic                  fin,
  output logic                  req_q,
  output logic                  irq,
  output logic                  done,
  output logic [CODE_W-1:0]     code
);
  logic [NUM_CAUSES-1:0] cause;
  logic                  run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      irq   <= 1'b0;
      cause <= '0;
    end else begin
      run_q <= run;
      req_q <= req;
      irq   <= |set_cause;
      cause <= run ? (cause | set_cause) : '0;
    end
  end

  // priority encoder: later (higher) index overrides earlier ones
  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_CAUSES; i++) begin
      if (cause[i]) code = CODE_W'(i + 1);
    end
  end

  assign fin  = |cause;
  assign done = run_q & ~busy;
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_run,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [STEP_W-1:0] step,
  input  logic              periph_req,
  input  logic              periph_term,
  output logic              periph_ack,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              stat_req,
  output logic [1:0]        stat_code,
  output logic              irq
);
  dmac_state_e           state;
  logic                  load, adv, at_end, fin;
  logic [NUM_CAUSES-1:0] set_cause;
  logic [CODE_W-1:0]     code;

  dmac_addr_ctr #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_addr (
    .clk(clk), .rst(rst), .load(load), .load_val(start_addr), .adv(adv),
    .step(step), .end_addr(end_addr), .addr(bus_addr), .at_end(at_end)
  );

  dmac_fsm u_fsm (
    .clk(clk), .rst(rst), .run(ctl_run), .fin(fin),
    .bad_range(end_addr < start_addr), .req(periph_req), .term(periph_term),
    .at_end(at_end), .bus_ack(bus_ack), .bus_err(bus_err), .state(state),
    .load(load), .adv(adv), .set_cause(set_cause)
  );

  assign stat_busy = (state != ST_IDLE);
  assign bus_req   = (state == ST_XFER);

  dmac_status u_stat (
    .clk(clk), .rst(rst), .run(ctl_run), .req(periph_req), .busy(stat_busy),
    .set_cause(set_cause), .fin(fin), .req_q(stat_req), .irq(irq),
    .done(stat_done), .code(code)
  );

  assign stat_code = 2'(code);

  always_ff @(posedge clk) begin
    if (rst) periph_ack <= 1'b0;
    else     periph_ack <= adv;
  end
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_run,
  input logic              periph_req,
  input logic [STEP_W-1:0] step,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              stat_busy,
  input logic              stat_done,
  input logic              stat_req,
  input logic [1:0]        stat_code,
  input logic              irq
);
  AST_BUSREQ_BUSY: assert property (@(posedge clk) disable iff (rst) bus_req |-> stat_busy); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) !ctl_run |=> (!bus_req && !stat_busy)); // R2
  AST_REQ_MIRROR: assert property (@(posedge clk) disable iff (rst) periph_req |=> stat_req); // R3
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (rst) !periph_req |=> !stat_req); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) (bus_req && bus_ack && !bus_err && ctl_run) |=> (bus_addr == $past(bus_addr) + ADDR_W'($past(step)))); // R4
  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (rst) (stat_code == 2'd3 && ctl_run) |=> stat_code == 2'd3); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst) (stat_done && ctl_run) |=> $stable(stat_code)); // R8
  AST_DONE_GATED: assert property (@(posedge clk) disable iff (rst) !ctl_run |=> !stat_done); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst) irq |-> stat_code != 2'd0); // R10
  AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (rst) !ctl_run |=> (stat_code == 2'd0 && !irq)); // R11
endmodule

bind dmac_chan dmac_chan_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_run(ctl_run), .periph_req(periph_req), .step(step),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err),
  .stat_busy(stat_busy), .stat_done(stat_done), .stat_req(stat_req),
  .stat_code(stat_code), .irq(irq)
);

// File: tb/dmac_chan_bench.sv
`timescale 1ns/100ps
module dmac_chan_bench;
  localparam int AW = 16;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_run = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic [SW-1:0] step = '0;
  logic          periph_req = 1'b0;
  logic          periph_term = 1'b0;
  logic          periph_ack;
  logic          bus_req;
  logic [AW-1:0] bus_addr;
  logic          bus_ack = 1'b0;
  logic          bus_err = 1'b0;
  logic          stat_busy, stat_done, stat_req, irq;
  logic [1:0]    stat_code;

  always #2.5 clk = ~clk;

  dmac_chan #(.ADDR_W(AW), .STEP_W(SW)) u_dmac_chan (
    .clk(clk), .rst(rst), .ctl_run(ctl_run), .start_addr(start_addr),
    .end_addr(end_addr), .step(step), .periph_req(periph_req),
    .periph_term(periph_term), .periph_ack(periph_ack), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err),
    .stat_busy(stat_busy), .stat_done(stat_done), .stat_req(stat_req),
    .stat_code(stat_code), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [AW-1:0] exp_q[$];
  int            lat = 0;
  int            wait_cnt = 0;
  logic [AW-1:0] err_at = '1;
  int            bus_cnt = 0;
  int            pack_cnt = 0;
  int            irq_cnt = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
      wait_cnt = 0;
    end else begin
      if (irq) irq_cnt++;
      if (periph_ack) pack_cnt++;
      if (bus_req && !bus_ack) begin
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          bus_cnt++;
          n_chk++;
          if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R4: actual bus address %0h expected no access", bus_addr);
          end else begin
            logic [AW-1:0] e;
            e = exp_q.pop_front();
            if (bus_addr !== e) begin
              n_err++;
              $display("FAIL R4: actual bus address %0h expected %0h", bus_addr, e);
            end
          end
          bus_ack = 1'b1;
          bus_err = (bus_addr == err_at);
        end
      end else begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
      end
    end
  end

  task automatic push_units(logic [AW-1:0] s, int st, int n);
    for (int k = 0; k < n; k++) exp_q.push_back(s + AW'(k * st));
  endtask

  task automatic start_run(logic [AW-1:0] s, logic [AW-1:0] e, int st);
    @(negedge clk);
    start_addr = s;
    end_addr = e;
    step = SW'(st);
    ctl_run = 1'b1;
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    @(negedge clk);
    while (stat_busy && g < 2000) begin
      @(negedge clk);
      g++;
    end
    #1;
  endtask

  task automatic stop_run();
    @(negedge clk);
    ctl_run = 1'b0;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    int i0, b0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy at reset", stat_busy, 0);
    check("R1 done at reset", stat_done, 0);
    check("R1 code at reset", stat_code, 0);
    check("R1 irq/bus_req at reset", {irq, bus_req, periph_ack}, 0);
    rst = 1'b0;

    // R4 R5 back-to-back, step 4
    i0 = irq_cnt; p0 = pack_cnt;
    push_units(16'h0100, 4, 4);
    periph_req = 1'b1;
    start_run(16'h0100, 16'h0110, 4);
    @(negedge clk);
    check("R1 busy while running", stat_busy, 1);
    wait_idle();
    check("R5 local done code", stat_code, 1);
    check("R9 done with run on", stat_done, 1);
    check("R4 all units issued", exp_q.size(), 0);
    check("R4 peripheral acks", pack_cnt - p0, 4);
    check("R10 one irq pulse", irq_cnt - i0, 1);
    periph_req = 1'b0;
    stop_run();
    check("R11 code cleared", stat_code, 0);
    check("R9 done off without run", stat_done, 0);

    // R4 wait states, step 2
    lat = 2; p0 = pack_cnt;
    push_units(16'h0180, 2, 3);
    periph_req = 1'b1;
    start_run(16'h0180, 16'h0186, 2);
    wait_idle();
    check("R4 wait-state units issued", exp_q.size(), 0);
    check("R4 wait-state acks", pack_cnt - p0, 3);
    check("R5 wait-state local done", stat_code, 1);
    periph_req = 1'b0;
    lat = 0;
    stop_run();

    // R5 zero length
    b0 = bus_cnt; i0 = irq_cnt;
    periph_req = 1'b1;
    start_run(16'h0060, 16'h0060, 4);
    wait_idle();
    check("R5 zero length code", stat_code, 1);
    check("R5 zero length no access", bus_cnt - b0, 0);
    check("R10 zero length irq", irq_cnt - i0, 1);
    periph_req = 1'b0;
    stop_run();

    // R2 R3 run off ignores requests
    b0 = bus_cnt;
    periph_req = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check("R2 no access while off", bus_cnt - b0, 0);
    check("R2 idle while off", stat_busy, 0);
    check("R3 request flag high", stat_req, 1);
    check("R9 done low while off", stat_done, 0);
    periph_req = 1'b0;
    @(negedge clk);
    #1;
    check("R3 request flag low", stat_req, 0);

    // R6 external termination, no units
    b0 = bus_cnt;
    start_run(16'h0200, 16'h0240, 4);
    @(negedge clk);
    periph_term = 1'b1;
    wait_idle();
    periph_term = 1'b0;
    check("R6 external code", stat_code, 2);
    check("R6 no access", bus_cnt - b0, 0);
    stop_run();

    // R8 priority: terminate as address reaches end
    i0 = irq_cnt;
    push_units(16'h0300, 4, 2);
    periph_req = 1'b1;
    start_run(16'h0300, 16'h0308, 4);
    begin
      int k, g;
      k = 0; g = 0;
      while (k < 2 && g < 500) begin
        @(negedge clk);
        if (periph_ack) k++;
        g++;
      end
    end
    periph_req = 1'b0;
    periph_term = 1'b1;
    wait_idle();
    periph_term = 1'b0;
    check("R8 external over local", stat_code, 2);
    check("R8 units before priority end", exp_q.size(), 0);
    check("R10 single irq for two causes", irq_cnt - i0, 1);
    repeat (3) @(negedge clk);
    #1;
    check("R8 code stable while done", stat_code, 2);
    stop_run();

    // R7 inverted range
    i0 = irq_cnt; b0 = bus_cnt;
    periph_req = 1'b1;
    start_run(16'h0050, 16'h0040, 4);
    @(negedge clk);
    #1;
    check("R7 range error code", stat_code, 3);
    check("R7 range error idle", stat_busy, 0);
    check("R9 done on error", stat_done, 1);
    repeat (5) @(negedge clk);
    #1;
    check("R7 range error latched", stat_code, 3);
    check("R7 no access on range error", bus_cnt - b0, 0);
    check("R10 range error irq", irq_cnt - i0, 1);
    periph_req = 1'b0;
    stop_run();
    check("R11 error cleared", stat_code, 0);

    // R7 bus error response mid-range
    p0 = pack_cnt;
    err_at = 16'h0408;
    push_units(16'h0400, 4, 3);
    periph_req = 1'b1;
    start_run(16'h0400, 16'h0410, 4);
    wait_idle();
    check("R7 bus error code", stat_code, 3);
    check("R7 no ack on errored unit", pack_cnt - p0, 2);
    check("R7 accesses up to error", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    #1;
    check("R7 bus error latched", stat_code, 3);
    periph_req = 1'b0;
    err_at = '1;
    stop_run();

    // R11 abort while waiting
    i0 = irq_cnt;
    start_run(16'h0500, 16'h0510, 4);
    @(negedge clk);
    #1;
    check("R11 busy before abort", stat_busy, 1);
    stop_run();
    check("R11 idle after abort", stat_busy, 0);
    check("R11 code after abort", stat_code, 0);
    check("R11 no irq on abort", irq_cnt - i0, 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule